// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed 8-bit two's-complement numbers over several clock cycles. It runs radix-2 Booth recoding one step per clock, using an accumulator, a multiplier shift register and a single guard bit. The guard bit sits just below the multiplier's least significant bit.

A caller pulses `start_i` while the block is idle. The multiplicand and multiplier are captured on that edge, and `busy_o` stays high while the block performs one step per clock. After the last step, `done_o` is high for a single cycle and `product_o` carries the signed 16-bit result. The result stays on `product_o` until the next accepted start.

Each step looks at the low multiplier bit together with the guard bit:
- If they differ, the multiplicand is added to the accumulator or subtracted from it.
- The accumulator, the multiplier register and the guard bit then shift right together, with sign extension.

The add/subtract path is one bit wider than the operands, so a multiplicand of -128 is handled exactly.

Top module: `booth_mul_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o` and `product_o` are all zero.
- R2: A `start_i` sampled high while `busy_o` is low captures both operands, and `busy_o` is high in the following cycle.
- R3: Exactly WIDTH (8) steps are executed. If start is sampled at edge k, `done_o` is high in the cycle after edge k+8.
- R4: `done_o` is high for exactly one cycle, and `busy_o` is low whenever `done_o` is high.
- R5: When `done_o` is high, `product_o` equals the signed product of the captured operands as a 16-bit two's-complement value. The accumulator forms bits 15..8 and the multiplier register forms bits 7..0.
- R6: An operand of -128 (8'h80) gives the exact result, including -128 x -128 = 16'h4000.
- R7: `start_i` is ignored while `busy_o` is high. The operation in flight completes with its own operands, and no extra operation or done pulse follows.
- R8: After `done_o`, `product_o` holds its value until the next accepted start.
- R9: A start sampled in the same cycle that `done_o` is high is accepted, so operations may run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| multiplicand_i | input | 8 | Signed multiplicand |
| multiplier_i | input | 8 | Signed multiplier |
| busy_o | output | 1 | High while steps are in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| product_o | output | 16 | Signed product |

## Verification
On every cycle, the assertions check the following:
- the single-cycle width of `done_o` and that it excludes `busy_o`;
- that `busy_o` rises only after a start;
- that exactly WIDTH busy cycles come before done;
- that the result equals the signed product of the operands captured at start;
- that the product is stable while idle.

Only the bench's scenarios can show the rest:
- that a start issued mid-operation leaves no trace;
- that starts issued in the done cycle chain correctly;
- the signed corner products around -128, -1, 0 and 127 across the full cross of those values.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      lsb_i,
  input  logic      guard_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({lsb_i, guard_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_SHIFT;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mq_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_op_e        op_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] mq_o,
  output logic             guard_o
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] acc_ext, mcand_ext, sum;

  // one guard bit so -2^(W-1) never overflows
  assign acc_ext   = {acc_i[WIDTH-1], acc_i};
  assign mcand_ext = {mcand_i[WIDTH-1], mcand_i};

  always_comb begin
    unique case (op_i)
      OP_ADD:  sum = acc_ext + mcand_ext;
      OP_SUB:  sum = acc_ext - mcand_ext;
      default: sum = acc_ext;
    endcase
  end

  // arithmetic right shift of the whole acc:mq:guard chain
  assign acc_o   = sum[EW-1:1];
  assign mq_o    = {sum[0], mq_i[WIDTH-1:1]};
  assign guard_o = mq_i[0];
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] step_cnt;
  logic             last_step;

  assign load_o    = start_i && !busy_o;
  assign step_o    = busy_o;
  assign last_step = busy_o && (step_cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      step_cnt <= '0;
    end else begin
      done_o <= last_step;
      if (load_o) begin
        busy_o   <= 1'b1;
        step_cnt <= '0;
      end else if (last_step) begin
        busy_o   <= 1'b0;
        step_cnt <= '0;
      end else if (busy_o) begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic             load, step;
  logic [WIDTH-1:0] mcand_q, acc_q, mq_q;
  logic             guard_q;
  logic [WIDTH-1:0] acc_n, mq_n;
  logic             guard_n;
  booth_op_e        op;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_recode u_recode (
    .lsb_i  (mq_q[0]),
    .guard_i(guard_q),
    .op_o   (op)
  );

  booth_step #(.WIDTH(WIDTH)) u_step (
    .acc_i  (acc_q),
    .mq_i   (mq_q),
    .mcand_i(mcand_q),
    .op_i   (op),
    .acc_o  (acc_n),
    .mq_o   (mq_n),
    .guard_o(guard_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      guard_q <= 1'b0;
    end else if (load) begin
      mcand_q <= multiplicand_i;
      acc_q   <= '0;
      mq_q    <= multiplier_i;
      guard_q <= 1'b0;
    end else if (step) begin
      acc_q   <= acc_n;
      mq_q    <= mq_n;
      guard_q <= guard_n;
    end
  end

  assign product_o = {acc_q, mq_q};
endmodule

// File: rtl/booth_mul_seq_chk.sv
module booth_mul_seq_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   multiplicand_i,
  input logic [WIDTH-1:0]   multiplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int CW = $clog2(WIDTH + 2) + 1;

  logic [WIDTH-1:0]          a_q, b_q;
  logic [CW-1:0]             busy_cnt;
  logic signed [2*WIDTH-1:0] expect_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      busy_cnt <= '0;
    end else if (start_i && !busy_o) begin
      a_q      <= multiplicand_i;
      b_q      <= multiplier_i;
      busy_cnt <= '0;
    end else if (busy_o && busy_cnt != {CW{1'b1}}) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  always_comb expect_p = (2*WIDTH)'($signed(a_q) * $signed(b_q));

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_step_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_cnt == CW'(WIDTH));
  assert_product_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> product_o == expect_p);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!done_o && !busy_o);
  end
endmodule

bind booth_mul_seq booth_mul_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .multiplicand_i(multiplicand_i),
  .multiplier_i  (multiplier_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .product_o     (product_o)
);

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mcand = '0, mplier = '0;
  logic        busy, done;
  logic [15:0] product;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] exp_q[$];
  int          cyc_q[$];
  logic [15:0] last_exp = '0;
  logic        prev_done = 1'b0;
  bit          finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  booth_mul_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .multiplicand_i(mcand), .multiplier_i(mplier),
    .busy_o(busy), .done_o(done), .product_o(product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int p;
    p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  task automatic do_mul(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(posedge clk); #1;
    exp_q.push_back(ref_mul(a, b));
    cyc_q.push_back(cyc);
    check(busy === 1'b1, "R2 R9 busy after start", busy, 1);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: scoreboard compare on done
  always @(negedge clk) begin
    if (rst_ni) begin
      check(!(done && prev_done), "R4 done width", 1, 0);
      if (done) begin
        check(!busy, "R4 busy with done", busy, 0);
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected done", product, 0);
        end else begin
          logic [15:0] e;
          int sc;
          e = exp_q.pop_front();
          sc = cyc_q.pop_front();
          last_exp = e;
          check(product === e, "R5 R6 product", product, e);
          check(cyc - sc == 8, "R3 latency", cyc - sc, 8);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] corners[8];
    int seed;
    corners = '{8'h80, 8'h81, 8'hFF, 8'h00, 8'h01, 8'h7F, 8'h55, 8'hAA};
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && product === 16'h0, "R1 reset state", product, 0);
    rst_ni = 1'b1;
    // R6 explicit corner
    do_mul(8'h80, 8'h80);
    // R5 R6 R9 corner cross, back to back
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_mul(corners[i], corners[j]);
    for (int k = 0; k < 40; k++) begin
      seed = seed * 1103515245 + 12345;
      do_mul(seed[23:16], seed[15:8]);
    end
    // R7: start mid-operation must be ignored
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    do_mul(8'h13, 8'hF7);
    repeat (2) @(negedge clk);
    start = 1'b1; mcand = 8'h7F; mplier = 8'h7F;
    @(negedge clk);
    start = 1'b0;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R7 no extra operation", busy, 0);
    // R8: product held while idle
    check(product === last_exp, "R8 hold after done", product, last_exp);
    repeat (5) @(negedge clk);
    check(product === last_exp, "R8 hold later", product, last_exp);
    check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule